// File: doc/BRIEF.md
# Loop Length Control Conditioner

This block turns a stream of 10-bit readings from a control knob's ADC into the loop length that a sample looper plays back. Readings arrive whenever the converter has one ready, and they are independent of the audio sample rate. The block sums 256 readings. It scales that sum to a 16-bit candidate length and raises any candidate below a floor up to that floor. It then accepts the candidate as the new target only when the candidate has moved far enough from the present target to count as a real turn of the knob rather than converter noise. An accepted target always has bit 0 cleared, so every target length is even.

A second register holds the active length, which is the length the looper actually uses. On each audio sample strobe the active length moves two counts toward the target. Turning the knob therefore glides the loop length smoothly instead of jumping, and the looper never sees a step large enough to click.

Top module: `loop_len_cond`

## Requirements
- R1: Each cycle with `adc_valid` high adds `adc_value` into a 24-bit sum. `target_len` can change only in the cycle that takes the 256th reading of a group; during the first 255 readings of a group it holds its value.
- R2: At the 256th reading the candidate length is the 24-bit sum, including that reading, shifted right by two and kept to 16 bits.
- R3: A candidate below 0x0200 is replaced by 0x0200, so `target_len` is never below 0x0200.
- R4: The target is replaced only if the absolute difference between the floored candidate and the current target is 0x0040 or more. A difference of exactly 0x0040 is accepted, and a difference of 0x003F leaves the target unchanged.
- R5: An accepted candidate is stored with bit 0 forced to 0, so `target_len` is always even.
- R6: The sum and the reading count restart from zero after every 256th reading, whether the candidate was accepted or rejected.
- R7: On a cycle with `sample_strobe` high, `active_len` increases by 2 if it is below `target_len`, decreases by 2 if it is above, and is unchanged if it is equal. The comparison uses the target held before that clock edge.
- R8: After reset, both `target_len` and `active_len` are 0x0600.
- R9: Readings are accepted with or without a strobe in the same cycle. On cycles without `sample_strobe`, `active_len` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_strobe | input | 1 | One-cycle pulse per audio sample period |
| adc_valid | input | 1 | One-cycle pulse marking a new knob reading |
| adc_value | input | 10 | Knob reading, unsigned |
| target_len | output | 16 | Conditioned target loop length |
| active_len | output | 16 | Loop length in use, slewed toward the target |

## Verification
The assertions rely on the inputs never forcing the active length to wrap. This holds because the target stays between the floor and the largest scaled sum, and the active length starts and stays even, so a step of 2 always lands exactly on an even target. The deadband and parity properties assume that at most one reading is taken per clock; the interface guarantees this, since it carries a single valid bit. The stimulus exercises both edges of the deadband: it uses groups whose sums give candidate differences of 0x0040 and 0x003F, and all-zero and all-one groups that fall under the floor. It also sends readings with and without simultaneous strobes, and inserts gaps between readings.

// File: rtl/loop_len_pkg.sv
package loop_len_pkg;
  localparam int LEN_W = 16;
  typedef logic [LEN_W-1:0] len_t;

  // raise a value up to a floor
  function automatic len_t llc_floor(len_t v, len_t lo);
    return (v < lo) ? lo : v;
  endfunction

  // magnitude of the distance between two lengths
  function automatic len_t llc_absdiff(len_t a, len_t b);
    return (a >= b) ? (a - b) : (b - a);
  endfunction

  // one slew step from cur toward goal
  function automatic len_t llc_toward(len_t cur, len_t goal, len_t step);
    if (cur < goal) return cur + step;
    if (cur > goal) return cur - step;
    return cur;
  endfunction

  // force an even value
  function automatic len_t llc_even(len_t v);
    return {v[LEN_W-1:1], 1'b0};
  endfunction
endpackage

// File: rtl/llc_averager.sv
module llc_averager #(
  parameter int ADC_W    = 10,
  parameter int ACC_W    = 24,
  parameter int AVG_LOG2 = 8,
  parameter int SHIFT    = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     valid,
  input  logic [ADC_W-1:0]         value,
  output logic                     eval_pulse,
  output loop_len_pkg::len_t       cand
);
  localparam logic [AVG_LOG2-1:0] LAST = {AVG_LOG2{1'b1}};

  logic [ACC_W-1:0]    acc_q;
  logic [AVG_LOG2-1:0] cnt_q;
  logic [ACC_W-1:0]    sum;

  assign sum        = acc_q + ACC_W'(value);
  assign eval_pulse = valid && (cnt_q == LAST);
  assign cand       = loop_len_pkg::LEN_W'(sum >> SHIFT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (valid) begin
      cnt_q <= cnt_q + 1'b1;
      acc_q <= eval_pulse ? '0 : sum;
    end
  end
endmodule

// File: rtl/llc_target.sv
module llc_target #(
  parameter loop_len_pkg::len_t MIN_LEN   = 16'h0200,
  parameter loop_len_pkg::len_t DEADBAND  = 16'h0040,
  parameter loop_len_pkg::len_t RESET_LEN = 16'h0600
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                eval_pulse,
  input  loop_len_pkg::len_t  cand,
  output logic                accept_pulse,
  output loop_len_pkg::len_t  target
);
  import loop_len_pkg::*;

  len_t floored;

  assign floored      = llc_floor(cand, MIN_LEN);
  assign accept_pulse = eval_pulse && (llc_absdiff(floored, target) >= DEADBAND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) target <= RESET_LEN;
    else if (accept_pulse) target <= llc_even(floored);
  end
endmodule

// File: rtl/llc_slew.sv
module llc_slew #(
  parameter loop_len_pkg::len_t STEP      = 16'd2,
  parameter loop_len_pkg::len_t RESET_LEN = 16'h0600
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                strobe,
  input  loop_len_pkg::len_t  target,
  output logic                moving,
  output loop_len_pkg::len_t  active
);
  import loop_len_pkg::*;

  assign moving = strobe && (active != target);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active <= RESET_LEN;
    else if (strobe) active <= llc_toward(active, target, STEP);
  end
endmodule

// File: rtl/loop_len_cond.sv
module loop_len_cond #(
  parameter int ADC_W    = 10,
  parameter int ACC_W    = 24,
  parameter int AVG_LOG2 = 8,
  parameter int SHIFT    = 2,
  parameter loop_len_pkg::len_t MIN_LEN   = 16'h0200,
  parameter loop_len_pkg::len_t DEADBAND  = 16'h0040,
  parameter loop_len_pkg::len_t RESET_LEN = 16'h0600,
  parameter loop_len_pkg::len_t STEP      = 16'd2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sample_strobe,
  input  logic                       adc_valid,
  input  logic [ADC_W-1:0]           adc_value,
  output logic [loop_len_pkg::LEN_W-1:0] target_len,
  output logic [loop_len_pkg::LEN_W-1:0] active_len
);
  import loop_len_pkg::*;

  logic eval_pulse;
  logic accept_pulse;
  logic moving;
  len_t cand_len;

  llc_averager #(
    .ADC_W(ADC_W), .ACC_W(ACC_W), .AVG_LOG2(AVG_LOG2), .SHIFT(SHIFT)
  ) u_avg (
    .clk(clk), .rst_n(rst_n), .valid(adc_valid), .value(adc_value),
    .eval_pulse(eval_pulse), .cand(cand_len)
  );

  llc_target #(
    .MIN_LEN(MIN_LEN), .DEADBAND(DEADBAND), .RESET_LEN(RESET_LEN)
  ) u_tgt (
    .clk(clk), .rst_n(rst_n), .eval_pulse(eval_pulse), .cand(cand_len),
    .accept_pulse(accept_pulse), .target(target_len)
  );

  llc_slew #(
    .STEP(STEP), .RESET_LEN(RESET_LEN)
  ) u_slew (
    .clk(clk), .rst_n(rst_n), .strobe(sample_strobe), .target(target_len),
    .moving(moving), .active(active_len)
  );
endmodule

// File: rtl/loop_len_cond_chk.sv
module loop_len_cond_chk #(
  parameter loop_len_pkg::len_t MIN_LEN  = 16'h0200,
  parameter loop_len_pkg::len_t DEADBAND = 16'h0040,
  parameter loop_len_pkg::len_t STEP     = 16'd2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sample_strobe,
  input logic               eval_pulse,
  input loop_len_pkg::len_t target_len,
  input loop_len_pkg::len_t active_len
);
  import loop_len_pkg::*;

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_pulse |=> $stable(target_len));

  p_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    target_len >= MIN_LEN);

  p_deadband_r4: assert property (@(posedge clk) disable iff (!rst_n)
    eval_pulse |=> (target_len == $past(target_len)) ||
                   (llc_absdiff(target_len, $past(target_len)) >= DEADBAND));

  p_even_r5: assert property (@(posedge clk) disable iff (!rst_n)
    target_len[0] == 1'b0);

  p_slew_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sample_strobe |=> (active_len == $past(active_len) + STEP) ||
                      (active_len == $past(active_len) - STEP) ||
                      ((active_len == $past(active_len)) &&
                       ($past(active_len) == $past(target_len))));

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_strobe |=> $stable(active_len));
endmodule

bind loop_len_cond loop_len_cond_chk #(
  .MIN_LEN(MIN_LEN), .DEADBAND(DEADBAND), .STEP(STEP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sample_strobe(sample_strobe),
  .eval_pulse(eval_pulse), .target_len(target_len), .active_len(active_len)
);

// File: tb/loop_len_cond_bench.sv
`timescale 1ns/1ps
module loop_len_cond_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_strobe = 1'b0;
  logic adc_valid = 1'b0;
  logic [9:0] adc_value = '0;
  logic [15:0] target_len;
  logic [15:0] active_len;

  int n_vec = 0;
  int n_bad = 0;
  int m_acc, m_cnt, m_tgt, m_act;

  always #10 clk = ~clk;

  loop_len_cond u_loop_len_cond (
    .clk(clk), .rst_n(rst_n), .sample_strobe(sample_strobe),
    .adc_valid(adc_valid), .adc_value(adc_value),
    .target_len(target_len), .active_len(active_len)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // one clock: inputs set at a falling edge, outputs compared at the next
  task automatic cyc(input logic s, input logic v, input int val);
    int old_tgt;
    sample_strobe = s; adc_valid = v; adc_value = val[9:0];
    @(posedge clk);
    old_tgt = m_tgt;
    if (v) begin
      m_acc = m_acc + val;
      if (m_cnt == 255) begin
        int c, d;
        c = (m_acc >> 2) & 16'hFFFF;
        if (c < 16'h0200) c = 16'h0200;
        d = (c > m_tgt) ? c - m_tgt : m_tgt - c;
        if (d >= 16'h0040) m_tgt = c & ~1;
        m_acc = 0; m_cnt = 0;
      end else m_cnt++;
    end
    if (s) begin
      if (m_act < old_tgt) m_act += 2;
      else if (m_act > old_tgt) m_act -= 2;
    end
    @(negedge clk);
    sample_strobe = 1'b0; adc_valid = 1'b0;
    chk("R7 R9 active model", active_len, m_act);
    chk("R1 R2 target model", target_len, m_tgt);
  endtask

  // a group of 256 readings: 255 of va, the last of vb
  task automatic group(input int va, input int vb, input logic s, input logic gap);
    for (int i = 0; i < 256; i++) begin
      if (i == 255) chk("R1 no update before 256th", target_len, m_tgt);
      cyc(s, 1'b1, (i == 255) ? vb : va);
      if (gap) cyc(1'b0, 1'b0, 0);
    end
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog: got 0 expected 1 (run complete)");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    m_acc = 0; m_cnt = 0; m_tgt = 16'h0600; m_act = 16'h0600;
    repeat (3) @(negedge clk);
    chk("R8 reset target", target_len, 16'h0600);
    chk("R8 reset active", active_len, 16'h0600);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: 256 readings of 600 -> 153600 >> 2 = 38400
    group(600, 600, 1'b0, 1'b0);
    chk("R2 scaled candidate", target_len, 38400);
    chk("R9 no strobe keeps active", active_len, 16'h0600);

    // R7: 100 strobes climb by 200
    for (int i = 0; i < 100; i++) cyc(1'b1, 1'b0, 0);
    chk("R7 climb by 2 per strobe", active_len, 16'h0600 + 200);

    // R3 and R9: all ones with a strobe each reading -> 64, floored
    group(1, 1, 1'b1, 1'b0);
    chk("R3 floor applied", target_len, 16'h0200);
    chk("R9 strobe with reading", active_len, 16'h06C8 + 512);

    // R7: descend to target, then hold when equal
    for (int i = 0; i < 868; i++) cyc(1'b1, 1'b0, 0);
    chk("R7 reached target", active_len, 16'h0200);
    for (int i = 0; i < 5; i++) cyc(1'b1, 1'b0, 0);
    chk("R7 equal holds", active_len, 16'h0200);

    // R4 R5: candidate 0x241, diff 0x41 -> accepted as 0x240, readings gapped
    group(9, 13, 1'b0, 1'b1);
    chk("R5 even target", target_len, 16'h0240);

    // R4: candidate 0x27F, diff 0x3F -> rejected
    group(10, 6, 1'b0, 1'b0);
    chk("R4 deadband rejects 0x3F", target_len, 16'h0240);

    // R6: zeros -> floor 0x200, diff exactly 0x40, accepted only if sum cleared
    group(0, 0, 1'b0, 1'b0);
    chk("R6 sum cleared after reject", target_len, 16'h0200);
    chk("R4 diff 0x40 accepted", target_len, 16'h0200);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule